// File: doc/BRIEF.md
# Memory Operand Effective Address Generator

This block turns the already-decoded address fields of a memory operand into a linear effective address and a segment number. The decoder supplies the operating width, which base and index registers to use, a scale code, a signed 32-bit displacement, an optional segment override and the address of the next instruction. The block puts the two register numbers on a register-file read port and receives their values back in the same cycle. It then forms base + index·scale + displacement, or the next-instruction address plus the displacement for instruction-relative operands.

The register-legality rules of each operating width are checked in the same path. The sum is wrapped to the active width. A default segment is chosen from the identity of the base register. The result, segment and an illegal-encoding flag are registered once per input strobe.

Register numbers follow the usual general-register order: 0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI, and 8 to 15 for the extended registers. Width codes are 0 for 16-bit, 1 for 32-bit, 2 for 64-bit and 3 reserved. Segment numbers are 0 ES, 1 CS, 2 SS, 3 DS, 4 FS and 5 GS.

Top module: `ea_gen`

## Requirements
- R1: In 64-bit mode the address is the sum of three terms, each optional: the base register value (if `base_vld`), the scaled index register value (if `idx_vld`), and the displacement sign-extended from 32 to 64 bits. With neither register present, the address is the sign-extended displacement alone.
- R2: Scale code 0, 1, 2 or 3 multiplies the index value by 1, 2, 4 or 8.
- R3: The encoding is illegal in any of these cases: the index register is 4 (the stack pointer), the width code is 3, or a register number of 8 or higher is used outside 64-bit mode. An illegal encoding sets `out_illegal`, and `out_ea` becomes 0.
- R4: Without an override, a base register of 4 or 5 selects segment 2 (stack). Any other base selects segment 3 (data). No base also selects segment 3, even when the index is register 5.
- R5: In 16-bit mode the base may only be absent, 3 or 5, and the index may only be absent, 6 or 7. A nonzero scale code is illegal. Base 5 selects segment 2 and base 3 selects segment 3.
- R6: In 16-bit mode the sum wraps modulo 2^16 and is zero-extended to the output width.
- R7: In 32-bit mode the sum wraps modulo 2^32 and is zero-extended to the output width.
- R8: With `rip_rel` set in 64-bit mode and no base or index, the address is `next_ip` plus the sign-extended displacement, and the segment is 3. `rip_rel` in any other mode, or together with a base or an index, is illegal.
- R9: One register may serve as both base and index. Its value then counts once as the base and once, scaled, as the index.
- R10: When `ovr_vld` is set, `out_seg` equals `ovr_seg`, whatever the default would have been.
- R11: `out_valid` equals `in_valid` delayed by one cycle. Results appear the cycle after the strobe and hold unchanged while `in_valid` is low.
- R12: After reset, `out_valid` is 0, `out_ea` is 0, `out_seg` is 3 and `out_illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Width code: 0 = 16, 1 = 32, 2 = 64 |
| base_vld | input | 1 | Base term present |
| base_reg | input | 4 | Base register number |
| idx_vld | input | 1 | Index term present |
| idx_reg | input | 4 | Index register number |
| scale | input | 2 | Index scale code |
| disp | input | 32 | Signed displacement |
| rip_rel | input | 1 | Instruction-relative form |
| next_ip | input | 64 | Address of the next instruction |
| ovr_vld | input | 1 | Segment override present |
| ovr_seg | input | 3 | Override segment number |
| rf_base_sel | output | 4 | Register-file read address, base |
| rf_idx_sel | output | 4 | Register-file read address, index |
| rf_base_val | input | 64 | Register-file read data, base |
| rf_idx_val | input | 64 | Register-file read data, index |
| out_valid | output | 1 | Result valid |
| out_ea | output | 64 | Effective address |
| out_seg | output | 3 | Selected segment number |
| out_illegal | output | 1 | Illegal encoding flag |

## Verification
The assertions check four things on every cycle: the one-cycle valid latency, results holding while idle, a stack-pointer index always being flagged, and the override always winning. They also check that 16-bit and 32-bit results never carry bits above their width. Only the bench's scenarios can show that the sums are arithmetically correct. The same holds for wrap-around at 2^16 and 2^32, the default-segment choice for each base register, and the instruction-relative form, because each needs known register values to predict the number.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW   = 64,
  parameter int DW   = 32,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              mode,
  input  logic                    base_vld,
  input  logic [$clog2(NREG)-1:0] base_reg,
  input  logic                    idx_vld,
  input  logic [$clog2(NREG)-1:0] idx_reg,
  input  logic [1:0]              scale,
  input  logic [DW-1:0]           disp,
  input  logic                    rip_rel,
  input  logic [AW-1:0]           next_ip,
  input  logic                    ovr_vld,
  input  logic [2:0]              ovr_seg,
  output logic [$clog2(NREG)-1:0] rf_base_sel,
  output logic [$clog2(NREG)-1:0] rf_idx_sel,
  input  logic [AW-1:0]           rf_base_val,
  input  logic [AW-1:0]           rf_idx_val,
  output logic                    out_valid,
  output logic [AW-1:0]           out_ea,
  output logic [2:0]              out_seg,
  output logic                    out_illegal
);
  localparam int RW = $clog2(NREG);
  localparam logic [1:0] M16 = 2'd0, M32 = 2'd1, M64 = 2'd2;
  localparam logic [2:0] SEG_SS = 3'd2, SEG_DS = 3'd3;
  localparam logic [RW-1:0] R_BX = RW'(3), R_SP = RW'(4), R_BP = RW'(5),
                            R_SI = RW'(6), R_DI = RW'(7);

  assign rf_base_sel = base_reg;
  assign rf_idx_sel  = idx_reg;

  logic [AW-1:0] disp_x, base_t, idx_t, sum, ea_w;
  assign disp_x = {{(AW-DW){disp[DW-1]}}, disp};
  assign base_t = base_vld ? rf_base_val : '0;
  assign idx_t  = idx_vld  ? (rf_idx_val << scale) : '0;
  assign sum    = rip_rel ? next_ip + disp_x : base_t + idx_t + disp_x;

  always_comb begin
    case (mode)
      M16:     ea_w = {{(AW-16){1'b0}}, sum[15:0]};
      M32:     ea_w = {{(AW-32){1'b0}}, sum[31:0]};
      default: ea_w = sum;
    endcase
  end

  logic high_reg, bad;
  assign high_reg = (base_vld && base_reg >= RW'(8)) || (idx_vld && idx_reg >= RW'(8));

  always_comb begin
    bad = 1'b0;
    if (mode == 2'd3) bad = 1'b1;
    if (idx_vld && idx_reg == R_SP) bad = 1'b1;
    if (rip_rel && (mode != M64 || base_vld || idx_vld)) bad = 1'b1;
    if (mode != M64 && high_reg) bad = 1'b1;
    if (mode == M16) begin
      if (base_vld && base_reg != R_BX && base_reg != R_BP) bad = 1'b1;
      if (idx_vld && idx_reg != R_SI && idx_reg != R_DI) bad = 1'b1;
      if (scale != 2'd0) bad = 1'b1;
    end
  end

  logic [2:0] seg_w;
  assign seg_w = ovr_vld ? ovr_seg :
                 (base_vld && !rip_rel && (base_reg == R_SP || base_reg == R_BP)) ? SEG_SS : SEG_DS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_ea      <= '0;
      out_seg     <= SEG_DS;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ea      <= bad ? '0 : ea_w;
        out_seg     <= seg_w;
        out_illegal <= bad;
      end
    end
  end

  assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_ea) && $stable(out_seg) && $stable(out_illegal));
  assert_sp_index_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && idx_vld && idx_reg == R_SP |=> out_illegal && out_ea == '0);
  assert_override_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ovr_vld |=> out_seg == $past(ovr_seg));
  assert_wrap16_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == M16 |=> out_ea[AW-1:16] == '0);
  assert_wrap32_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == M32 |=> out_ea[AW-1:32] == '0);
endmodule

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic in_valid = 0, base_vld = 0, idx_vld = 0, rip_rel = 0, ovr_vld = 0;
  logic [1:0] mode = 0, scale = 0;
  logic [3:0] base_reg = 0, idx_reg = 0, rf_base_sel, rf_idx_sel;
  logic [31:0] disp = 0;
  logic [63:0] next_ip = 0, rf_base_val, rf_idx_val, out_ea;
  logic [2:0] ovr_seg = 0, out_seg;
  logic out_valid, out_illegal;

  logic [63:0] regs [16];
  assign rf_base_val = regs[rf_base_sel];
  assign rf_idx_val  = regs[rf_idx_sel];

  ea_gen dut (.clk, .rst_n, .in_valid, .mode, .base_vld, .base_reg, .idx_vld, .idx_reg,
    .scale, .disp, .rip_rel, .next_ip, .ovr_vld, .ovr_seg, .rf_base_sel, .rf_idx_sel,
    .rf_base_val, .rf_idx_val, .out_valid, .out_ea, .out_seg, .out_illegal);

  int n_vec = 0, n_bad = 0;

  function automatic logic [63:0] sx(input logic [31:0] d);
    return {{32{d[31]}}, d};
  endfunction

  task automatic chk(input string tag, input logic [63:0] e_ea, input logic [2:0] e_seg,
                     input logic e_ill);
    n_vec++;
    if (out_ea !== e_ea || out_seg !== e_seg || out_illegal !== e_ill || out_valid !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: ea=%h seg=%0d ill=%b v=%b, expected ea=%h seg=%0d ill=%b v=1",
               tag, out_ea, out_seg, out_illegal, out_valid, e_ea, e_seg, e_ill);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic bv, input logic [3:0] br,
                       input logic iv, input logic [3:0] ir, input logic [1:0] sc,
                       input logic [31:0] d, input logic rr, input logic ov,
                       input logic [2:0] os);
    @(negedge clk);
    mode = m; base_vld = bv; base_reg = br; idx_vld = iv; idx_reg = ir; scale = sc;
    disp = d; rip_rel = rr; ovr_vld = ov; ovr_seg = os; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset;
    n_vec++;
    if (out_valid !== 0 || out_ea !== 0 || out_seg !== 3'd3 || out_illegal !== 0) begin
      n_bad++;
      $display("FAIL R12: v=%b ea=%h seg=%0d ill=%b, expected v=0 ea=0 seg=3 ill=0",
               out_valid, out_ea, out_seg, out_illegal);
    end
  endtask

  task automatic t_full64;
    apply(2, 1, 1, 1, 6, 3, 32'hFFFF_FFF0, 0, 0, 0);
    chk("R1 full", regs[1] + (regs[6] << 3) + sx(32'hFFFF_FFF0), 3'd3, 0);
    apply(2, 0, 0, 0, 0, 0, 32'h8000_0010, 0, 0, 0);
    chk("R1 direct", 64'hFFFF_FFFF_8000_0010, 3'd3, 0);
    apply(2, 1, 9, 0, 0, 0, 32'h0000_0040, 0, 0, 0);
    chk("R1 base only", regs[9] + 64'h40, 3'd3, 0);
  endtask

  task automatic t_scales;
    for (int s = 0; s < 4; s++) begin
      apply(2, 0, 0, 1, 5, s[1:0], 32'h4, 0, 0, 0);
      chk("R2/R4 scaled idx no base", (regs[5] << s) + 64'h4, 3'd3, 0);
    end
  endtask

  task automatic t_segments;
    apply(2, 1, 4, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 sp base", regs[4], 3'd2, 0);
    apply(2, 1, 5, 1, 7, 1, 0, 0, 0, 0);
    chk("R4 bp base", regs[5] + (regs[7] << 1), 3'd2, 0);
    apply(1, 1, 3, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 bx base", regs[3] & 64'hFFFF_FFFF, 3'd3, 0);
  endtask

  task automatic t_illegal;
    apply(2, 1, 1, 1, 4, 0, 32'h100, 0, 0, 0);
    chk("R3 sp index", 64'h0, 3'd3, 1);
    apply(3, 1, 1, 0, 0, 0, 32'h100, 0, 0, 0);
    chk("R3 reserved mode", 64'h0, 3'd3, 1);
    apply(1, 1, 10, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 high reg in 32", 64'h0, 3'd3, 1);
  endtask

  task automatic t_mode16;
    apply(0, 1, 5, 1, 6, 0, 32'h0000_F600, 0, 0, 0);
    chk("R5/R6 bp+si wrap", (regs[5] + regs[6] + 64'hF600) & 64'hFFFF, 3'd2, 0);
    apply(0, 1, 3, 1, 7, 0, 32'hFFFF_FFFE, 0, 0, 0);
    chk("R5/R6 bx+di", (regs[3] + regs[7] - 64'd2) & 64'hFFFF, 3'd3, 0);
    apply(0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 bad base", 64'h0, 3'd3, 1);
    apply(0, 1, 3, 1, 3, 0, 0, 0, 0, 0);
    chk("R5 bad index", 64'h0, 3'd3, 1);
    apply(0, 1, 3, 1, 6, 1, 0, 0, 0, 0);
    chk("R5 scale", 64'h0, 3'd3, 1);
  endtask

  task automatic t_mode32;
    apply(1, 1, 2, 0, 0, 0, 32'hFFFF_FFFC, 0, 0, 0);
    chk("R7 neg disp", (regs[2] - 64'd4) & 64'hFFFF_FFFF, 3'd3, 0);
    apply(1, 1, 15, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 high reg", 64'h0, 3'd3, 1);
    apply(1, 1, 0, 1, 1, 3, 32'hF000_0000, 0, 0, 0);
    chk("R7 wrap", (regs[0] + (regs[1] << 3) + sx(32'hF000_0000)) & 64'hFFFF_FFFF, 3'd3, 0);
  endtask

  task automatic t_rip;
    next_ip = 64'h0000_7FFF_0000_1000;
    apply(2, 0, 0, 0, 0, 0, 32'hFFFF_FFF8, 1, 0, 0);
    chk("R8 rip", 64'h0000_7FFF_0000_0FF8, 3'd3, 0);
    apply(1, 0, 0, 0, 0, 0, 32'h8, 1, 0, 0);
    chk("R8 rip in 32", 64'h0, 3'd3, 1);
    apply(2, 1, 5, 0, 0, 0, 32'h8, 1, 0, 0);
    chk("R8 rip with base", 64'h0, 3'd3, 1);
  endtask

  task automatic t_same_reg;
    apply(2, 1, 7, 1, 7, 2, 32'h1, 0, 0, 0);
    chk("R9 same reg", regs[7] + (regs[7] << 2) + 64'h1, 3'd3, 0);
  endtask

  task automatic t_override;
    apply(2, 1, 5, 0, 0, 0, 0, 0, 1, 3'd4);
    chk("R10 override on bp", regs[5], 3'd4, 0);
    apply(2, 1, 3, 0, 0, 0, 0, 0, 1, 3'd0);
    chk("R10 override on bx", regs[3], 3'd0, 0);
  endtask

  task automatic t_latency;
    logic [63:0] held;
    apply(2, 1, 3, 0, 0, 0, 32'h20, 0, 0, 0);
    held = regs[3] + 64'h20;
    chk("R11 result", held, 3'd3, 0);
    base_reg = 4'd5; disp = 32'h999;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 0 || out_ea !== held || out_seg !== 3'd3) begin
      n_bad++;
      $display("FAIL R11 idle: v=%b ea=%h seg=%0d, expected v=0 ea=%h seg=3",
               out_valid, out_ea, out_seg, held);
    end
  endtask

  bit done = 0;
  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 64'h0123_4567_89AB_0000 + 64'(i) * 64'h1111;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_full64();
    t_scales();
    t_segments();
    t_illegal();
    t_mode16();
    t_mode32();
    t_rip();
    t_same_reg();
    t_override();
    t_latency();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule